// File: doc/BRIEF.md
# Supply Monitor Power-Fail Sequencer

This block turns three supply comparator outputs into an ordered set of protective actions for a processor subsystem. The comparators report that the supply has fallen below a warning level, below the minimum operating level, and below the battery switchover level. These levels are ordered warning above minimum above battery. Each raw comparator output is brought into the clock domain by a two-flop synchronizer. It is then filtered by a debounce counter whose length software sets through the `debounceLen` input.

A five-state controller acts on the filtered levels, one action per level. At the warning level it can raise an interrupt request carrying the fixed vector 2Bh. At the minimum level it holds the processor in reset and forces every external chip enable and the read/write strobe high. At the lowest level it also selects the backup battery. On recovery from battery, main power is taken back first. Reset is released only after a fixed stabilization delay. The datapath holds the synchronizers, the debounce filters, the interrupt flag and the stabilization counter. The controller drives the datapath through a small strobe bundle.

Top module: `pfail_sequencer`

## Requirements
- R1: On a move from normal operation into the warning-only state with `warnIntEn` high, `intReq` rises and `intVector` reads 8'h2B. With `warnIntEn` low, no request is made. `intVector` reads 8'h00 whenever `intReq` is low.
- R2: While only the warning comparator is active, `cpuResetHold`, `busDisable` and `onBattery` stay low, and `ceOutN`/`rwOutN` follow `ceReqN`/`rwReqN`.
- R3: Once the minimum-level comparator is active, `cpuResetHold` is held high. It drops as soon as that comparator clears, provided the battery level was not reached.
- R4: While `busDisable` is high, every bit of `ceOutN` and `rwOutN` is 1. `busDisable` is high exactly when `cpuResetHold` is high.
- R5: `onBattery` is high only while the battery comparator is active. Whenever it is high, the reset hold is also high.
- R6: On a fall, the states are entered in order. The reset hold is already high in the cycle before `onBattery` rises, even when all three comparators switch at once. A fall straight to the minimum level raises no interrupt.
- R7: `intReq` stays high until `intAck` is pulsed or the reset hold asserts. It is not raised again until the filtered supply has returned above the warning level.
- R8: On recovery from the battery state, `onBattery` drops first. `cpuResetHold` stays high for STAB_CYCLES further cycles before it is released.
- R9: A comparator change reaches the filtered level only after it has been seen in synchronized form for `debounceLen`+1 consecutive cycles. Shorter pulses have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| belowWarnRaw | input | 1 | Asynchronous comparator: supply below warning level |
| belowMinRaw | input | 1 | Asynchronous comparator: supply below minimum operating level |
| belowBatRaw | input | 1 | Asynchronous comparator: supply below battery switch level |
| warnIntEn | input | 1 | Enables the early-warning interrupt |
| intAck | input | 1 | Clears a pending interrupt request |
| debounceLen | input | DEB_W | Debounce length; a change must persist debounceLen+1 cycles |
| ceReqN | input | NUM_CE | Active-low chip enables from the bus logic |
| rwReqN | input | 1 | Read/write strobe from the bus logic (1 = inactive) |
| intReq | output | 1 | Pending power-fail interrupt request |
| intVector | output | 8 | Interrupt vector, 8'h2B while requesting |
| cpuResetHold | output | 1 | Holds the processor in reset |
| busDisable | output | 1 | Forces chip enables and read/write inactive |
| onBattery | output | 1 | Selects the backup battery as supply |
| ceOutN | output | NUM_CE | Gated chip enables to memories and peripherals |
| rwOutN | output | 1 | Gated read/write strobe |

## Verification
A raw comparator change takes two edges to synchronize. It takes `debounceLen`+1 more edges to reach the filtered level, and one further edge to reach the state register and its outputs. With `debounceLen` = 2, the outputs therefore move on the sixth rising edge after the input changes. Release from a battery recovery comes STAB_CYCLES edges later still. The bench changes inputs on the falling edge. The vector table waits 20 cycles per row, well past every latency, before it samples. The directed tests sample one time unit after chosen rising edges: one edge before each result is due, to see that it has not yet arrived, and again after it is due.

// File: rtl/pfail_pkg.sv
package pfail_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL = 3'd0,
    ST_WARN   = 3'd1,
    ST_RESET  = 3'd2,
    ST_BATT   = 3'd3,
    ST_STAB   = 3'd4
  } pfState_e;

  typedef struct packed {
    logic intSet;
    logic intClr;
    logic stabRun;
  } pfStrobe_t;

  localparam logic [7:0] PF_VECTOR = 8'h2B;
  localparam int NUM_LEVELS = 3;

endpackage

// File: rtl/pfail_datapath.sv
module pfail_datapath
  import pfail_pkg::*;
#(
  parameter int DEB_W       = 8,
  parameter int STAB_CYCLES = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] rawLevel,
  input  logic [DEB_W-1:0]      debounceLen,
  input  logic                  intAck,
  input  pfStrobe_t             strobe,
  output logic [NUM_LEVELS-1:0] filtLevel,
  output logic                  stabDone,
  output logic                  intReq
);

  localparam int STAB_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [STAB_W-1:0] STAB_LAST = STAB_W'(STAB_CYCLES - 1);

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_chan
    logic meta, syncd;
    logic [DEB_W-1:0] debCnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta         <= 1'b0;
        syncd        <= 1'b0;
        debCnt       <= '0;
        filtLevel[i] <= 1'b0;
      end else begin
        meta  <= rawLevel[i];
        syncd <= meta;
        if (syncd == filtLevel[i]) begin
          debCnt <= '0;
        end else if (debCnt >= debounceLen) begin
          filtLevel[i] <= syncd;
          debCnt       <= '0;
        end else begin
          debCnt <= debCnt + 1'b1;
        end
      end
    end
  end

  logic [STAB_W-1:0] stabCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stabCnt <= '0;
    end else if (!strobe.stabRun) begin
      stabCnt <= '0;
    end else if (stabCnt != STAB_LAST) begin
      stabCnt <= stabCnt + 1'b1;
    end
  end

  assign stabDone = strobe.stabRun && (stabCnt == STAB_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intReq <= 1'b0;
    end else if (strobe.intSet) begin
      intReq <= 1'b1;
    end else if (strobe.intClr || intAck) begin
      intReq <= 1'b0;
    end
  end

endmodule

// File: rtl/pfail_control.sv
module pfail_control
  import pfail_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LEVELS-1:0] filtLevel,
  input  logic                  stabDone,
  input  logic                  warnIntEn,
  output pfStrobe_t             strobe,
  output logic                  holdReset,
  output logic                  selBattery
);

  // filtLevel bit 0 = below warning, bit 1 = below minimum, bit 2 = below battery
  logic [1:0] depth;
  always_comb begin
    if (filtLevel[2])      depth = 2'd3;
    else if (filtLevel[1]) depth = 2'd2;
    else if (filtLevel[0]) depth = 2'd1;
    else                   depth = 2'd0;
  end

  pfState_e state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_NORMAL: if (depth >= 2'd2) nextState = ST_RESET;
                 else if (depth == 2'd1) nextState = ST_WARN;
      ST_WARN:   if (depth >= 2'd2) nextState = ST_RESET;
                 else if (depth == 2'd0) nextState = ST_NORMAL;
      ST_RESET:  if (depth == 2'd3) nextState = ST_BATT;
                 else if (depth == 2'd1) nextState = ST_WARN;
                 else if (depth == 2'd0) nextState = ST_NORMAL;
      ST_BATT:   if (depth != 2'd3) nextState = ST_STAB;
      ST_STAB:   if (depth == 2'd3) nextState = ST_BATT;
                 else if (stabDone) begin
                   if (depth == 2'd2)      nextState = ST_RESET;
                   else if (depth == 2'd1) nextState = ST_WARN;
                   else                    nextState = ST_NORMAL;
                 end
      default:   nextState = ST_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_NORMAL;
    else       state <= nextState;
  end

  assign holdReset  = (state == ST_RESET) || (state == ST_BATT) || (state == ST_STAB);
  assign selBattery = (state == ST_BATT);

  always_comb begin
    strobe.intSet  = (state == ST_NORMAL) && (nextState == ST_WARN) && warnIntEn;
    strobe.intClr  = holdReset;
    strobe.stabRun = (state == ST_STAB);
  end

endmodule

// File: rtl/pfail_sequencer.sv
module pfail_sequencer
  import pfail_pkg::*;
#(
  parameter int DEB_W       = 8,
  parameter int STAB_CYCLES = 16,
  parameter int NUM_CE      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              belowWarnRaw,
  input  logic              belowMinRaw,
  input  logic              belowBatRaw,
  input  logic              warnIntEn,
  input  logic              intAck,
  input  logic [DEB_W-1:0]  debounceLen,
  input  logic [NUM_CE-1:0] ceReqN,
  input  logic              rwReqN,
  output logic              intReq,
  output logic [7:0]        intVector,
  output logic              cpuResetHold,
  output logic              busDisable,
  output logic              onBattery,
  output logic [NUM_CE-1:0] ceOutN,
  output logic              rwOutN
);

  pfStrobe_t             strobe;
  logic [NUM_LEVELS-1:0] filtLevel;
  logic                  stabDone;
  logic                  holdReset;

  pfail_datapath #(.DEB_W(DEB_W), .STAB_CYCLES(STAB_CYCLES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rawLevel   ({belowBatRaw, belowMinRaw, belowWarnRaw}),
    .debounceLen(debounceLen),
    .intAck     (intAck),
    .strobe     (strobe),
    .filtLevel  (filtLevel),
    .stabDone   (stabDone),
    .intReq     (intReq)
  );

  pfail_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .filtLevel (filtLevel),
    .stabDone  (stabDone),
    .warnIntEn (warnIntEn),
    .strobe    (strobe),
    .holdReset (holdReset),
    .selBattery(onBattery)
  );

  assign cpuResetHold = holdReset;
  assign busDisable   = holdReset;
  assign ceOutN       = busDisable ? '1 : ceReqN;
  assign rwOutN       = busDisable | rwReqN;
  assign intVector    = intReq ? PF_VECTOR : 8'h00;

endmodule

// File: rtl/pfail_sequencer_chk.sv
module pfail_sequencer_chk #(
  parameter int NUM_CE = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              warnIntEn,
  input logic              intAck,
  input logic              intReq,
  input logic [7:0]        intVector,
  input logic              cpuResetHold,
  input logic              busDisable,
  input logic              onBattery,
  input logic [NUM_CE-1:0] ceOutN,
  input logic              rwOutN
);

  AST_VECTOR_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> intVector == 8'h2B); // R1

  AST_INT_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> $past(warnIntEn)); // R1

  AST_INT_NOT_IN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> !cpuResetHold); // R2

  AST_BUS_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    busDisable |-> (&ceOutN) && rwOutN); // R4

  AST_BATT_UNDER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    onBattery |-> cpuResetHold && busDisable); // R5

  AST_BATT_ORDERED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(onBattery) |-> $past(cpuResetHold)); // R6

  AST_INT_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    intReq && !intAck && !cpuResetHold |=> intReq); // R7

  AST_MAINS_BEFORE_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(onBattery) |-> cpuResetHold); // R8

endmodule

bind pfail_sequencer pfail_sequencer_chk #(.NUM_CE(NUM_CE)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .warnIntEn   (warnIntEn),
  .intAck      (intAck),
  .intReq      (intReq),
  .intVector   (intVector),
  .cpuResetHold(cpuResetHold),
  .busDisable  (busDisable),
  .onBattery   (onBattery),
  .ceOutN      (ceOutN),
  .rwOutN      (rwOutN)
);

// File: tb/pfail_sequencer_bench.sv
module pfail_sequencer_bench;

  localparam int DEB_W  = 8;
  localparam int STAB   = 8;
  localparam int NUM_CE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic belowWarnRaw = 1'b0, belowMinRaw = 1'b0, belowBatRaw = 1'b0;
  logic warnIntEn = 1'b0, intAck = 1'b0;
  logic [DEB_W-1:0] debounceLen = 8'd2;
  logic [NUM_CE-1:0] ceReqN = 4'b1010;
  logic rwReqN = 1'b0;
  logic intReq, cpuResetHold, busDisable, onBattery, rwOutN;
  logic [7:0] intVector;
  logic [NUM_CE-1:0] ceOutN;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pfail_sequencer #(.DEB_W(DEB_W), .STAB_CYCLES(STAB), .NUM_CE(NUM_CE)) u_pfail_sequencer (
    .clk(clk), .rstN(rstN),
    .belowWarnRaw(belowWarnRaw), .belowMinRaw(belowMinRaw), .belowBatRaw(belowBatRaw),
    .warnIntEn(warnIntEn), .intAck(intAck), .debounceLen(debounceLen),
    .ceReqN(ceReqN), .rwReqN(rwReqN),
    .intReq(intReq), .intVector(intVector), .cpuResetHold(cpuResetHold),
    .busDisable(busDisable), .onBattery(onBattery), .ceOutN(ceOutN), .rwOutN(rwOutN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setLevel(input logic [2:0] lvl);
    @(negedge clk);
    {belowWarnRaw, belowMinRaw, belowBatRaw} = lvl;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // row: [6:4] raw {warn,min,bat}, [3] enable, [2] intReq, [1] reset hold, [0] battery
  localparam logic [6:0] TBL [0:10] = '{
    7'b000_1_000,  // normal
    7'b100_1_100,  // warning raises request
    7'b110_1_010,  // reset clears request
    7'b111_1_011,  // battery
    7'b110_1_010,  // back on mains, still under minimum
    7'b100_1_000,  // reset released, no new request
    7'b000_1_000,
    7'b100_0_000,  // warning with interrupt disabled
    7'b000_1_000,
    7'b100_1_100,  // request
    7'b000_1_100   // still pending after recovery
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    edges(3);
    check("R2 reset hold after reset", cpuResetHold, 0);
    check("R2 ce passthrough", ceOutN, 4'b1010);
    check("R1 vector idle", intVector, 8'h00);
    @(negedge clk) rstN = 1'b1;
    edges(2);

    for (int i = 0; i < 11; i++) begin
      @(negedge clk);
      warnIntEn = TBL[i][3];
      {belowWarnRaw, belowMinRaw, belowBatRaw} = TBL[i][6:4];
      edges(20);
      check($sformatf("R1/R7 row %0d intReq", i), intReq, TBL[i][2]);
      check($sformatf("R3/R6 row %0d reset", i), cpuResetHold, TBL[i][1]);
      check($sformatf("R5 row %0d battery", i), onBattery, TBL[i][0]);
      if (TBL[i][2]) check($sformatf("R1 row %0d vector", i), intVector, 8'h2B);
    end

    // R7: acknowledge clears the pending request
    @(negedge clk) intAck = 1'b1;
    @(negedge clk) intAck = 1'b0;
    edges(2);
    check("R7 ack clears", intReq, 0);

    // R9: latency and short pulses
    warnIntEn = 1'b1;
    setLevel(3'b100);
    edges(4);
    check("R9 not yet filtered", intReq, 0);
    edges(3);
    check("R9 filtered after debounce", intReq, 1);
    @(negedge clk) intAck = 1'b1;
    @(negedge clk) intAck = 1'b0;
    setLevel(3'b000);
    edges(12);
    setLevel(3'b100);
    setLevel(3'b100);
    setLevel(3'b000);
    edges(12);
    check("R9 short warning pulse ignored", intReq, 0);
    setLevel(3'b110);
    setLevel(3'b110);
    setLevel(3'b000);
    edges(12);
    check("R9 short minimum pulse ignored", cpuResetHold, 0);

    // R2 / R4: bus gating
    ceReqN = 4'b0000;
    rwReqN = 1'b0;
    setLevel(3'b100);
    edges(12);
    check("R2 warning keeps bus live", {ceOutN, rwOutN}, 5'b00000);
    check("R2 warning no reset", cpuResetHold, 0);
    setLevel(3'b110);
    edges(12);
    check("R4 ce forced high", ceOutN, 4'b1111);
    check("R4 rw forced high", rwOutN, 1);
    check("R4 bus disable", busDisable, 1);
    check("R7 reset cleared request", intReq, 0);
    setLevel(3'b000);
    edges(12);
    check("R3 release without delay", cpuResetHold, 0);

    // R6: sudden full drop, no interrupt
    setLevel(3'b111);
    edges(12);
    check("R6 fast drop battery", onBattery, 1);
    check("R6 fast drop no int", intReq, 0);

    // R8: recovery from battery
    setLevel(3'b000);
    edges(12);
    check("R8 mains first", onBattery, 0);
    check("R8 reset still held", cpuResetHold, 1);
    edges(4);
    check("R8 reset released", cpuResetHold, 0);
    check("R8 no request on recovery", intReq, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule